// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block converts parallel characters into an asynchronous serial stream on a single output line. A character written through a one-cycle write strobe lands in a holding register. From there it moves into a shift register as soon as the line is free. A second character can be accepted while the first is still shifting out. Each frame is built from four parts: one low start bit, five to eight data bits sent least significant bit first, an optional parity bit, and a stop period that lasts one, one-and-a-half or two bit times. The line idles high.

All timing comes from a single-cycle clock-enable pulse that arrives sixteen times per bit period. The baud-rate divider sits outside the block. The frame settings (length, parity mode, forced parity level, stop length) are taken when a character moves from the holding register into the shifter.

A break command holds the line low for as long as it is asserted. If a character is on the line when the command arrives, the break waits until that character's stop period has ended. After the break ends, the line is driven high for one bit time before anything else is sent. Two status outputs report whether the holding register is free and whether the whole path is idle.

Top module: `sertx_core`

## Requirements
- R1: After reset `txd` is 1, `ready` is 1 and `empty` is 1.
- R2: A frame starts with one low start bit of 16 ticks. It is followed by the data bits, least significant first, each lasting 16 ticks. `cfg_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the selected length are never sent.
- R3: `cfg_par` = 1 (even) adds a parity bit that makes the count of ones across the data bits and the parity bit even. `cfg_par` = 2 (odd) makes that count odd. The parity bit lasts 16 ticks and follows the last data bit.
- R4: `cfg_par` = 0 sends no parity bit. `cfg_par` = 3 sends a parity bit equal to `cfg_force_lvl`, whatever the data.
- R5: The stop period drives the line high. `cfg_stop` = 0 gives 16 ticks, 1 gives 24 ticks, and 2 or 3 give 32 ticks.
- R6: A write with `ready` high is captured, and `ready` is low in the next cycle. When a character is waiting in the holding register, its start bit follows the previous frame's stop period with no idle tick between them.
- R7: A write made while `ready` is low is dropped and never appears on the line.
- R8: `empty` is high only when the holding register is free and no frame, break or recovery period is in progress. While `empty` is high, `txd` is 1 and `ready` is 1.
- R9: `brk_req` asserted while the block is empty drives `txd` low from the next cycle. The line stays low for as long as `brk_req` stays high.
- R10: `brk_req` raised while a frame is being sent leaves that frame, including its full stop period, intact. The break then begins, and a character waiting in the holding register stays there until the break ends.
- R11: When `brk_req` falls, the line is driven high for 16 ticks, and `empty` stays low during that time. Only then does a waiting character's start bit begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Clock-enable pulse, 16 per bit period |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to send |
| cfg_len | input | 2 | Data length code (5 to 8 bits) |
| cfg_par | input | 2 | Parity mode: none, even, odd, forced |
| cfg_force_lvl | input | 1 | Parity level used in forced mode |
| cfg_stop | input | 2 | Stop length code: 1, 1.5 or 2 bit times |
| brk_req | input | 1 | Break command, line held low while high |
| txd | output | 1 | Serial output line |
| ready | output | 1 | Holding register free |
| empty | output | 1 | Holding register and shifter both idle |

## Verification
The assertions assume that `tick16` is a single-cycle pulse and that the frame settings do not change in the cycle a character moves into the shifter. They also assume `brk_req` is a level held for many cycles, not a glitch. The stimulus drives every input one time unit after the rising edge. It spaces the tick pulses four cycles apart and changes the frame settings only while `empty` is high. The bench records the line once per tick and compares that per-tick stream against frames it builds from the requirements.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_FORCE = 2'd3
    } par_e;

    typedef enum logic [1:0] {
        STOP_ONE  = 2'd0,
        STOP_HALF = 2'd1,
        STOP_TWO  = 2'd2,
        STOP_TWOB = 2'd3
    } stop_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_DATA  = 3'd2,
        PH_PAR   = 3'd3,
        PH_STOP  = 3'd4,
        PH_BRK   = 3'd5,
        PH_RCV   = 3'd6
    } phase_e;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              valid,
    output logic [DATA_W-1:0] data
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) begin
            hold_d.valid = 1'b0;
        end
        if (wr_en && !hold_q.valid) begin
            hold_d.valid = 1'b1;
            hold_d.data  = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign valid = hold_q.valid;
    assign data  = hold_q.data;

endmodule

// File: rtl/sertx_parity.sv
module sertx_parity
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]         data,
    input  logic [$clog2(DATA_W)-1:0] last_idx,
    input  logic [1:0]                mode,
    input  logic                      force_lvl,
    output logic                      pbit,
    output logic                      par_en
);

    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] in_frame;

    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign in_frame[g] = data[g] & (IDX_W'(g) <= last_idx);
    end

    always_comb begin
        par_en = (par_e'(mode) != PAR_NONE);
        unique case (par_e'(mode))
            PAR_EVEN:  pbit = ^in_frame;
            PAR_ODD:   pbit = ~(^in_frame);
            PAR_FORCE: pbit = force_lvl;
            default:   pbit = 1'b0;
        endcase
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      brk_req,
    input  logic                      hold_valid,
    input  logic [DATA_W-1:0]         hold_data,
    input  logic [$clog2(DATA_W)-1:0] last_idx,
    input  logic                      pbit,
    input  logic                      par_en,
    input  logic [1:0]                stop_code,
    output logic                      take,
    output logic                      txd,
    output logic                      idle
);

    localparam int IDX_W = $clog2(DATA_W);
    localparam int CNT_W = $clog2(2 * OVS);
    localparam logic [CNT_W-1:0] LIM_ONE  = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(OVS + OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LIM_TWO  = CNT_W'(2 * OVS - 1);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic [DATA_W-1:0] sh;
        logic              pbit;
        logic              par_en;
        logic [1:0]        stop;
    } shf_t;

    shf_t             shf_d, shf_q;
    logic [CNT_W-1:0] lim;
    logic             bit_end;
    logic             launch;

    always_comb begin
        shf_d  = shf_q;
        take   = 1'b0;
        launch = 1'b0;

        lim = LIM_ONE;
        if (shf_q.ph == PH_STOP) begin
            unique case (stop_e'(shf_q.stop))
                STOP_ONE:  lim = LIM_ONE;
                STOP_HALF: lim = LIM_HALF;
                default:   lim = LIM_TWO;
            endcase
        end
        bit_end = tick && (shf_q.cnt == lim);

        if (tick && shf_q.ph != PH_IDLE && shf_q.ph != PH_BRK) begin
            shf_d.cnt = bit_end ? '0 : shf_q.cnt + CNT_W'(1);
        end

        unique case (shf_q.ph)
            PH_IDLE: launch = 1'b1;
            PH_START: begin
                if (bit_end) begin
                    shf_d.ph  = PH_DATA;
                    shf_d.idx = '0;
                end
            end
            PH_DATA: begin
                if (bit_end) begin
                    shf_d.sh = shf_q.sh >> 1;
                    if (shf_q.idx == shf_q.last) begin
                        shf_d.ph = shf_q.par_en ? PH_PAR : PH_STOP;
                    end else begin
                        shf_d.idx = shf_q.idx + IDX_W'(1);
                    end
                end
            end
            PH_PAR: begin
                if (bit_end) begin
                    shf_d.ph = PH_STOP;
                end
            end
            PH_STOP, PH_RCV: begin
                if (bit_end) begin
                    launch = 1'b1;
                end
            end
            PH_BRK: begin
                if (!brk_req) begin
                    shf_d.ph  = PH_RCV;
                    shf_d.cnt = '0;
                end
            end
            default: shf_d.ph = PH_IDLE;
        endcase

        // Break outranks a waiting character; otherwise chain without a gap.
        if (launch) begin
            shf_d.cnt = '0;
            if (brk_req) begin
                shf_d.ph = PH_BRK;
            end else if (hold_valid) begin
                take         = 1'b1;
                shf_d.ph     = PH_START;
                shf_d.sh     = hold_data;
                shf_d.last   = last_idx;
                shf_d.pbit   = pbit;
                shf_d.par_en = par_en;
                shf_d.stop   = stop_code;
            end else begin
                shf_d.ph = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shf_q <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

    always_comb begin
        unique case (shf_q.ph)
            PH_START: txd = 1'b0;
            PH_DATA:  txd = shf_q.sh[0];
            PH_PAR:   txd = shf_q.pbit;
            PH_BRK:   txd = 1'b0;
            default:  txd = 1'b1;
        endcase
    end

    assign idle = (shf_q.ph == PH_IDLE);

endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_force_lvl,
    input  logic [1:0]        cfg_stop,
    input  logic              brk_req,
    output logic              txd,
    output logic              ready,
    output logic              empty
);

    localparam int IDX_W   = $clog2(DATA_W);
    localparam int MIN_LEN = DATA_W - 3;

    logic              hold_valid;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic [IDX_W-1:0]  last_idx;
    logic              pbit;
    logic              par_en;
    logic              sh_idle;

    assign last_idx = IDX_W'(MIN_LEN - 1) + IDX_W'(cfg_len);

    sertx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .valid   (hold_valid),
        .data    (hold_data)
    );

    sertx_parity #(.DATA_W(DATA_W)) u_parity (
        .data      (hold_data),
        .last_idx  (last_idx),
        .mode      (cfg_par),
        .force_lvl (cfg_force_lvl),
        .pbit      (pbit),
        .par_en    (par_en)
    );

    sertx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .brk_req    (brk_req),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .last_idx   (last_idx),
        .pbit       (pbit),
        .par_en     (par_en),
        .stop_code  (cfg_stop),
        .take       (take),
        .txd        (txd),
        .idle       (sh_idle)
    );

    assign ready = !hold_valid;
    assign empty = !hold_valid && sh_idle;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic brk_req,
    input logic txd,
    input logic ready,
    input logic empty
);

    // R6
    write_takes_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ready) |=> !ready);

    // R8
    empty_has_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> ready);

    // R8
    empty_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> txd);

    // R9
    break_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && empty) |=> !txd);

    // R11
    release_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk_req && $past(brk_req) && !txd) |=> !empty);

endmodule

bind sertx_core sertx_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .brk_req (brk_req),
    .txd     (txd),
    .ready   (ready),
    .empty   (empty)
);

// File: tb/test_sertx_core.sv
`timescale 1ns/1ps
module test_sertx_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_force_lvl = 1'b0;
    logic [1:0] cfg_stop = 2'd0;
    logic       brk_req = 1'b0;
    logic       txd, ready, empty;

    int n_chk = 0;
    int n_bad = 0;
    logic rec [0:4095];
    int   nrec = 0;
    logic ex  [0:4095];
    int   nex = 0;

    sertx_core i_sertx_core (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_force_lvl(cfg_force_lvl),
        .cfg_stop(cfg_stop), .brk_req(brk_req), .txd(txd), .ready(ready), .empty(empty)
    );

    always #5 clk = ~clk;

    // tick pulse: one cycle high every four cycles, changed after the edge
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 tick16 = 1'b1;
            @(posedge clk);
            #1 tick16 = 1'b0;
        end
    end

    // one line sample per tick, taken at the falling edge
    always @(negedge clk) begin
        if (tick16 && nrec < 4096) begin
            rec[nrec] = txd;
            nrec++;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL all: watchdog expired, got hang expected completion");
        summary();
        $finish;
    end

    task automatic chk(string tag, int got, int exp_v);
        n_chk++;
        if (got !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp_v);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(logic [1:0] len, logic [1:0] par, logic flvl, logic [1:0] stp);
        step(1);
        cfg_len = len; cfg_par = par; cfg_force_lvl = flvl; cfg_stop = stp;
    endtask

    task automatic write_char(logic [7:0] d);
        step(1);
        wr_en = 1'b1; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic wait_rec(int n);
        while (nrec < n) @(negedge clk);
    endtask

    task automatic add_bits(logic v, int cnt);
        for (int k = 0; k < cnt; k++) begin
            ex[nex] = v;
            nex++;
        end
    endtask

    // expected frame from the requirements, using the current configuration
    task automatic add_frame(logic [7:0] d);
        int   len;
        logic ones;
        len  = 5 + int'(cfg_len);
        ones = 1'b0;
        add_bits(1'b0, 16);
        for (int i = 0; i < len; i++) begin
            add_bits(d[i], 16);
            ones ^= d[i];
        end
        case (cfg_par)
            2'd1: add_bits(ones, 16);
            2'd2: add_bits(~ones, 16);
            2'd3: add_bits(cfg_force_lvl, 16);
            default: ;
        endcase
        case (cfg_stop)
            2'd0: add_bits(1'b1, 16);
            2'd1: add_bits(1'b1, 24);
            default: add_bits(1'b1, 32);
        endcase
    endtask

    task automatic cmp_stream(string tag, logic skipv);
        int base;
        int bad;
        base = 0;
        bad  = -1;
        while (base < nrec && rec[base] === skipv) base++;
        for (int k = 0; k < nex; k++) begin
            if (bad < 0 && (base + k >= nrec || rec[base + k] !== ex[k])) bad = k;
        end
        n_chk++;
        if (bad >= 0) begin
            n_bad++;
            $display("FAIL %s: tick sample %0d got %b expected %b", tag, bad,
                     (base + bad < nrec) ? rec[base + bad] : 1'bx, ex[bad]);
        end
    endtask

    task automatic single_frame(string tag, logic [7:0] d);
        nrec = 0; nex = 0;
        add_frame(d);
        add_bits(1'b1, 4);
        write_char(d);
        wait_rec(nex + 4);
        cmp_stream(tag, 1'b1);
        chk({tag, " empty after frame"}, int'(empty), 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd", int'(txd), 1);
        chk("R1 ready", int'(ready), 1);
        chk("R1 empty", int'(empty), 1);
    endtask

    task automatic t_frames();
        set_cfg(2'd3, 2'd0, 1'b0, 2'd0);
        single_frame("R2 R5 8 bits no parity one stop", 8'hA5);
        set_cfg(2'd0, 2'd1, 1'b0, 2'd0);
        single_frame("R2 R3 5 bits even parity", 8'hF3);
        set_cfg(2'd2, 2'd2, 1'b0, 2'd1);
        single_frame("R3 R5 7 bits odd parity 1.5 stop", 8'h5C);
        set_cfg(2'd1, 2'd3, 1'b1, 2'd2);
        single_frame("R4 R5 6 bits forced high two stop", 8'h2A);
        set_cfg(2'd3, 2'd3, 1'b0, 2'd3);
        single_frame("R4 R5 8 bits forced low stop code 3", 8'hFF);
    endtask

    task automatic t_back_to_back();
        set_cfg(2'd3, 2'd0, 1'b0, 2'd0);
        nrec = 0; nex = 0;
        add_frame(8'h31);
        add_frame(8'hC4);
        add_bits(1'b1, 4);
        write_char(8'h31);
        @(negedge clk);
        chk("R6 ready low after write", int'(ready), 0);
        chk("R8 empty low after write", int'(empty), 0);
        step(2);
        @(negedge clk);
        chk("R6 ready back once shifting", int'(ready), 1);
        chk("R8 empty low while shifting", int'(empty), 0);
        write_char(8'hC4);
        wait_rec(nex + 4);
        cmp_stream("R6 two frames without gap", 1'b1);
    endtask

    task automatic t_drop();
        set_cfg(2'd3, 2'd1, 1'b0, 2'd0);
        nrec = 0; nex = 0;
        add_frame(8'h11);
        add_frame(8'h22);
        add_bits(1'b1, 20);
        write_char(8'h11);
        step(2);
        write_char(8'h22);
        @(negedge clk);
        chk("R7 ready low before extra write", int'(ready), 0);
        write_char(8'h33);
        wait_rec(nex + 4);
        cmp_stream("R7 write while full dropped", 1'b1);
    endtask

    task automatic t_break_idle();
        nrec = 0; nex = 0;
        add_bits(1'b0, 30);
        step(1);
        brk_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R9 line low next cycle", int'(txd), 0);
        chk("R9 ready during break", int'(ready), 1);
        wait_rec(40);
        cmp_stream("R9 line held low", 1'b1);
        step(1);
        brk_req = 1'b0;
        step(2);
        @(negedge clk);
        chk("R11 empty low in recovery", int'(empty), 0);
        chk("R11 line high in recovery", int'(txd), 1);
        step(55);
        @(negedge clk);
        chk("R11 still recovering", int'(empty), 0);
        step(12);
        @(negedge clk);
        chk("R11 empty after recovery", int'(empty), 1);
    endtask

    task automatic t_break_mid();
        set_cfg(2'd3, 2'd1, 1'b0, 2'd0);
        nrec = 0; nex = 0;
        add_frame(8'h96);
        add_bits(1'b0, 20);
        write_char(8'h96);
        step(3);
        brk_req = 1'b1;
        write_char(8'h0F);
        wait_rec(nex + 4);
        cmp_stream("R10 frame completes before break", 1'b1);
        @(negedge clk);
        chk("R10 waiting char held during break", int'(ready), 0);
        step(1);
        brk_req = 1'b0;
        nrec = 0; nex = 0;
        add_bits(1'b1, 16);
        add_frame(8'h0F);
        add_bits(1'b1, 4);
        wait_rec(nex + 4);
        cmp_stream("R11 one idle bit then waiting char", 1'b0);
    endtask

    initial begin
        t_reset();
        t_frames();
        t_back_to_back();
        t_drop();
        t_break_idle();
        t_break_mid();
        step(4);
        summary();
        $finish;
    end

endmodule